// File: doc/BRIEF.md
# Field-Synchronous Overlay Toggle Controller

This controller decides, per channel, whether an extra keyed layer (a clock logo or a caption, for example) is laid over the background picture. Each channel has a debounced push button and host command inputs. A host command can toggle the channel or force it on or off. Each channel drives an enable level to the mixer and an indicator LED that mirrors that level.

A request never acts at once. It is first latched. The controller then waits for a falling edge of line sync. From that point it counts falling edges of field blanking and applies the change on the sixth one, so the switch always lands at the same point in the vertical interval. Clearing an enable returns the output to the plain background. Requests that arrive while another change is in flight are held per channel. When the current change is done they are served, lowest channel first. Line sync and field blanking come from another clock domain. Each passes through a synchronizer before its edges are detected.

Top module: `overlay_toggle_ctrl`

## Requirements
- R1: A rising edge on `btn_i[c]` requests a toggle of channel c.
- R2: Channels are independent and both may be on at once. At most one enable output changes in any clock cycle.
- R3: `led_o[c]` equals `ovl_en_o[c]` in every cycle.
- R4: Field-blanking falling edges that occur after a request is captured but before the next line-sync falling edge are not counted.
- R5: The enable changes on exactly the sixth field-blanking falling edge (high to low) after the line-sync falling edge (high to low), and not on any earlier one.
- R6: A one-cycle pulse on `host_tgl_i[c]` requests a toggle of channel c, the same as a button press.
- R7: A pulse on `host_set_i[c]` requests that channel c be set to `host_val_i[c]` (1 = overlay shown, 0 = background only). It uses the same line and field alignment and leaves the channel unchanged if it already has that value.
- R8: A request for a channel that arrives while a change is in flight is held and served after the current change completes. When several channels are pending, the lowest index is served first.
- R9: When requests meet in one cycle on one channel, an explicit set wins over a toggle. A button press and a host toggle together count as one toggle. A newer held request replaces an older held one.
- R10: While `rst_ni` is low, all enables and LEDs are 0, no request is held and the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_i | input | NCH | Debounced button levels, synchronous to clk_i |
| host_tgl_i | input | NCH | Host toggle request pulses |
| host_set_i | input | NCH | Host explicit-set request pulses |
| host_val_i | input | NCH | Value used with host_set_i |
| lsync_i | input | 1 | Line sync, asynchronous, falling edge used |
| fblank_i | input | 1 | Field blanking, asynchronous, falling edge used |
| ovl_en_o | output | NCH | Overlay enable levels to the mixer |
| led_o | output | NCH | Indicator LEDs, mirror of ovl_en_o |

## Verification
The two functions that can land in one cycle are the capture of a new request and the service of an earlier one. The bench drives a button press and a host set on the same channel in one cycle, and it also presses both buttons at once. Both cases are judged by the enable value after each full line-plus-six-field sequence. A request made partway through a field count must not disturb that count. The bench checks this by showing that the value is unchanged after the fifth edge and correct after the sixth, and that the held request is applied only by the following sequence.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LINE  = 2'd1,
    ST_FIELD = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ovl_sync_fall.sv
module ovl_sync_fall #(
  parameter int   STAGES  = 2,
  parameter logic RST_LVL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {STAGES{RST_LVL}};
      prev_q <= RST_LVL;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/ovl_req_slot.sv
module ovl_req_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  input  logic host_tgl_i,
  input  logic host_set_i,
  input  logic host_val_i,
  input  logic take_i,
  output logic pend_o,
  output logic op_set_o,
  output logic op_val_o
);
  logic btn_q, pend_q, set_q, val_q;
  logic rise, req;

  assign rise = btn_i & ~btn_q;
  assign req  = rise | host_tgl_i | host_set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      btn_q  <= 1'b0;
      pend_q <= 1'b0;
      set_q  <= 1'b0;
      val_q  <= 1'b0;
    end else begin
      btn_q <= btn_i;
      if (req) begin
        // newest request replaces any held one; set beats toggle
        pend_q <= 1'b1;
        set_q  <= host_set_i;
        val_q  <= host_set_i & host_val_i;
      end else if (take_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign pend_o   = pend_q;
  assign op_set_o = set_q;
  assign op_val_o = val_q;
endmodule

// File: rtl/ovl_seq.sv
module ovl_seq
  import ovl_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int EDGES = 6,
  localparam int CW   = (EDGES > 1) ? $clog2(EDGES) : 1,
  localparam int SW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] pend_i,
  input  logic [NCH-1:0] op_set_i,
  input  logic [NCH-1:0] op_val_i,
  input  logic           ls_fall_i,
  input  logic           fb_fall_i,
  output logic [NCH-1:0] take_o,
  output logic [NCH-1:0] en_o,
  output seq_state_e     state_o
);
  localparam logic [CW-1:0] LAST = CW'(EDGES - 1);

  seq_state_e     state_q;
  logic [CW-1:0]  cnt_q;
  logic [SW-1:0]  sel_q, pick;
  logic           set_q, val_q;
  logic [NCH-1:0] en_q;

  always_comb begin
    pick = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (pend_i[c]) pick = SW'(c);
    end
  end

  always_comb begin
    take_o = '0;
    if (state_q == ST_IDLE && |pend_i) take_o[pick] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sel_q   <= '0;
      set_q   <= 1'b0;
      val_q   <= 1'b0;
      en_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (|pend_i) begin
          sel_q   <= pick;
          set_q   <= op_set_i[pick];
          val_q   <= op_val_i[pick];
          state_q <= ST_LINE;
        end
        ST_LINE: if (ls_fall_i) begin
          cnt_q   <= '0;
          state_q <= ST_FIELD;
        end
        ST_FIELD: if (fb_fall_i) begin
          if (cnt_q == LAST) begin
            en_q[sel_q] <= set_q ? val_q : ~en_q[sel_q];
            state_q     <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign en_o    = en_q;
  assign state_o = state_q;
endmodule

// File: rtl/overlay_toggle_ctrl.sv
module overlay_toggle_ctrl
  import ovl_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int EDGES       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] btn_i,
  input  logic [NCH-1:0] host_tgl_i,
  input  logic [NCH-1:0] host_set_i,
  input  logic [NCH-1:0] host_val_i,
  input  logic           lsync_i,
  input  logic           fblank_i,
  output logic [NCH-1:0] ovl_en_o,
  output logic [NCH-1:0] led_o
);
  logic           ls_fall, fb_fall;
  logic [NCH-1:0] pend, op_set, op_val, take, en;
  seq_state_e     seq_state;

  ovl_sync_fall #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_ls_sync (
    .clk_i, .rst_ni, .d_i(lsync_i), .fall_o(ls_fall)
  );

  ovl_sync_fall #(.STAGES(SYNC_STAGES), .RST_LVL(1'b0)) u_fb_sync (
    .clk_i, .rst_ni, .d_i(fblank_i), .fall_o(fb_fall)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_slot
    ovl_req_slot u_slot (
      .clk_i, .rst_ni,
      .btn_i      (btn_i[c]),
      .host_tgl_i (host_tgl_i[c]),
      .host_set_i (host_set_i[c]),
      .host_val_i (host_val_i[c]),
      .take_i     (take[c]),
      .pend_o     (pend[c]),
      .op_set_o   (op_set[c]),
      .op_val_o   (op_val[c])
    );
  end

  ovl_seq #(.NCH(NCH), .EDGES(EDGES)) u_seq (
    .clk_i, .rst_ni,
    .pend_i    (pend),
    .op_set_i  (op_set),
    .op_val_i  (op_val),
    .ls_fall_i (ls_fall),
    .fb_fall_i (fb_fall),
    .take_o    (take),
    .en_o      (en),
    .state_o   (seq_state)
  );

  assign ovl_en_o = en;
  assign led_o    = en;
endmodule

// File: rtl/ovl_toggle_chk.sv
module ovl_toggle_chk
  import ovl_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int EDGES = 6
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NCH-1:0] ovl_en_o,
  input logic [NCH-1:0] led_o,
  input seq_state_e     state_i,
  input logic           ls_fall_i,
  input logic           fb_fall_i
);
  int fcnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                fcnt <= 0;
    else if (state_i != ST_FIELD) fcnt <= 0;
    else if (fb_fall_i)         fcnt <= fcnt + 1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_off_r10: assert (ovl_en_o == '0 && led_o == '0 && state_i == ST_IDLE);
    end
  end

  p_led_mirror_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_o == ovl_en_o);

  p_one_change_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ovl_en_o ^ $past(ovl_en_o)) <= 1);

  p_hold_line_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_LINE && !ls_fall_i) |=> state_i == ST_LINE);

  p_field_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovl_en_o != $past(ovl_en_o)) |-> $past(fb_fall_i && state_i == ST_FIELD));

  p_sixth_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovl_en_o != $past(ovl_en_o)) |-> $past(fcnt) == EDGES - 1);

  p_idle_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_IDLE |=> $stable(ovl_en_o));
endmodule

bind overlay_toggle_ctrl ovl_toggle_chk #(.NCH(NCH), .EDGES(EDGES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ovl_en_o  (ovl_en_o),
  .led_o     (led_o),
  .state_i   (seq_state),
  .ls_fall_i (ls_fall),
  .fb_fall_i (fb_fall)
);

// File: tb/overlay_toggle_ctrl_tb.sv
module overlay_toggle_ctrl_tb;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NCH-1:0] btn = '0, htgl = '0, hset = '0, hval = '0;
  logic lsync = 1'b1, fblank = 1'b0;
  logic [NCH-1:0] en, led;
  logic [NCH-1:0] expv = '0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  overlay_toggle_ctrl #(.NCH(NCH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .btn_i(btn), .host_tgl_i(htgl),
    .host_set_i(hset), .host_val_i(hval), .lsync_i(lsync), .fblank_i(fblank),
    .ovl_en_o(en), .led_o(led)
  );

  task automatic chk(string req, logic [NCH-1:0] exp_v);
    checks++;
    if (en !== exp_v || led !== exp_v) begin
      fails++;
      $display("FAIL %s en=%b led=%b expected=%b", req, en, led, exp_v);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic line_pulse();
    lsync = 1'b0; cyc(4); lsync = 1'b1; cyc(4);
  endtask

  task automatic field_pulse();
    fblank = 1'b1; cyc(4); fblank = 1'b0; cyc(6);
  endtask

  // op: 0 button, 1 host toggle, 2 set off, 3 set on
  task automatic issue(int ch, int op);
    @(negedge clk);
    case (op)
      0: btn[ch] = 1'b1;
      1: htgl[ch] = 1'b1;
      default: begin hset[ch] = 1'b1; hval[ch] = (op == 3); end
    endcase
    @(negedge clk);
    htgl = '0; hset = '0; hval = '0;
    cyc(1); btn = '0; cyc(2);
  endtask

  // line edge, five field edges (no change), sixth (change to nxt)
  task automatic run_seq(string req, logic [NCH-1:0] nxt);
    logic [NCH-1:0] old = en;
    line_pulse();
    for (int i = 0; i < 5; i++) field_pulse();
    chk({req, " before sixth field edge (R5)"}, old);
    field_pulse();
    chk(req, nxt);
  endtask

  initial begin
    cyc(3);
    chk("R10 reset", '0);
    rst_ni = 1'b1;
    cyc(3);
    chk("R10 idle after reset", '0);

    // R1 R6 R7 sweep over channel, operation and start value
    for (int ch = 0; ch < NCH; ch++)
      for (int op = 0; op < 4; op++)
        for (int st = 0; st < 2; st++) begin
          issue(ch, st ? 3 : 2);
          expv[ch] = st[0];
          run_seq("R7 set start", expv);
          issue(ch, op);
          if (op < 2) expv[ch] = ~expv[ch];
          else        expv[ch] = (op == 3);
          run_seq(op == 0 ? "R1 button" : (op == 1 ? "R6 host toggle" : "R7 host set"), expv);
        end

    // R2 both on
    issue(0, 3); expv[0] = 1'b1; run_seq("R2 ch0 on", expv);
    issue(1, 3); expv[1] = 1'b1; run_seq("R2 both on", expv);

    // R4 field edges before line edge ignored
    issue(0, 0);
    for (int i = 0; i < 6; i++) field_pulse();
    chk("R4 no line edge yet", expv);
    expv[0] = 1'b0;
    run_seq("R4 after line edge", expv);

    // R8 both buttons together: ch0 first, then ch1
    @(negedge clk); btn = 2'b11; cyc(2); btn = '0; cyc(2);
    expv[0] = 1'b1; run_seq("R8 lower channel first", expv);
    expv[1] = 1'b0; run_seq("R8 held channel served", expv);

    // R8 request mid-count on the in-flight channel
    issue(0, 1);
    line_pulse();
    field_pulse(); field_pulse();
    issue(0, 1);
    for (int i = 0; i < 3; i++) field_pulse();
    chk("R8 count not disturbed after fifth", expv);
    field_pulse();
    expv[0] = 1'b0;
    chk("R8 in-flight change applied", expv);
    expv[0] = 1'b1;
    run_seq("R8 held request applied next", expv);

    // R9 set beats button in one cycle; button+host toggle is one toggle
    @(negedge clk); btn[1] = 1'b1; hset[1] = 1'b1; hval[1] = 1'b0;
    @(negedge clk); hset = '0; btn = '0; cyc(2);
    run_seq("R9 set wins over press", expv);
    line_pulse();
    for (int i = 0; i < 6; i++) field_pulse();
    chk("R9 nothing further held", expv);
    @(negedge clk); btn[1] = 1'b1; htgl[1] = 1'b1;
    @(negedge clk); htgl = '0; btn = '0; cyc(2);
    expv[1] = 1'b1; run_seq("R9 press and host toggle as one", expv);
    line_pulse();
    for (int i = 0; i < 6; i++) field_pulse();
    chk("R9 single toggle only", expv);

    // R9 newer held request replaces older
    issue(0, 1);
    issue(1, 1);
    issue(1, 2);
    expv[0] = 1'b0; run_seq("R9 first", expv);
    expv[1] = 1'b0; run_seq("R9 newest held wins", expv);

    // R10 reset mid-sequence clears all
    issue(0, 1);
    line_pulse(); field_pulse();
    rst_ni = 1'b0; cyc(2);
    chk("R10 reset mid-sequence", '0);
    rst_ni = 1'b1; cyc(2);
    expv = '0;
    line_pulse();
    for (int i = 0; i < 6; i++) field_pulse();
    chk("R10 nothing held after reset", expv);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired en=%b expected=%b", en, expv);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule